// File: doc/BRIEF.md
# Safety Error Signaling Aggregator

This block gathers error events from 128 single-cycle error lines and sorts them into three severity groups. Group 1 has 64 channels, exposed as a low word (channels 0-31) and a high word (channels 32-63). Group 2 and group 3 have 32 channels each. Every event sets a sticky flag for its channel. Group 1 raises a low-priority interrupt for each channel whose interrupt enable is set. Group 2 raises a high-priority interrupt. Group 3 raises no interrupt. Group 2 and group 3 events always pull the active-low error output down. A group 1 event pulls it down only when that channel's pin enable is set. Once down, the output stays latched until software writes the release key or a power-on reset occurs.

There are two reset domains. Power-on reset clears everything, and while it is held the error output driver is disabled. Warm reset clears only the group 2 flags and the configuration registers. The group 1 flags, the group 3 flags, a shadow copy of the group 2 flags and the error output level all survive it. Software accesses the block over a simple word-addressed register bus. Reads are combinational and take effect at the clock edge. Two offset registers report the lowest pending channel. Reading the high-priority offset register also clears the group 2 flag it reports.

Top module: `esa_top`

## Requirements
- R1: A one-cycle pulse on an event input sets that channel's flag at the next clock edge. The flag then holds. Status reads use these addresses: 0 returns group 1 channels 0-31, 1 returns channels 32-63, 2 returns group 2 and 3 returns group 3, with channel n at bit n of its word.
- R2: Writing to address 0 or 1 clears each group 1 flag whose data bit is 1. Data bits of 0 leave their flags unchanged.
- R3: `irq_lo` is high while any group 1 flag is set together with its interrupt enable. Enables are at address 6 (channels 0-31) and address 7 (channels 32-63). `irq_hi` is high while any group 2 flag is set.
- R4: An event on any group 2 or group 3 channel drives `err_pin` low at the next edge. A group 1 event does so only when its pin enable is set. Pin enables are at address 8 (channels 0-31) and address 9 (channels 32-63). Bit 0 of address 5 reads the current `err_pin` level.
- R5: `err_pin` stays low until a write to address 10 whose low four bits equal 4'h5. Writes to address 10 with any other value leave it low. When an error event arrives in the same cycle as the release write, the pin stays low.
- R6: Address 4 returns a shadow word that gains a bit whenever the matching group 2 flag is set. Only power-on reset clears it. Offset reads and warm reset leave it unchanged.
- R7: While `por_n` is low, `err_pin_oe` is 0. After power-on reset, every status word, the shadow, the enables and the offsets read 0, and `err_pin` is 1.
- R8: While `warm_n` is low, `err_pin_oe` stays 1. Warm reset clears the group 2 flags and the enable registers. The group 1 flags, the group 3 flags, the shadow and the `err_pin` level are kept.
- R9: A group 1 flag kept through warm reset drives `irq_lo` high once its interrupt enable is written again.
- R10: A read of address 11 returns the lowest set group 2 channel plus one, or 0 when none is set. The same read clears that one group 2 flag and nothing else. When a new event hits that channel in the same cycle, the flag stays set.
- R11: A read of address 12 returns the lowest set group 1 channel plus one, or 0 when none is set. It clears no flag.
- R12: A write to address 13 with data bit 0 set drives `err_pin` low, as an error would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_n | input | 1 | Synchronous warm reset, active low |
| evt_g1 | input | 64 | Group 1 event pulses |
| evt_g2 | input | 32 | Group 2 event pulses |
| evt_g3 | input | 32 | Group 3 event pulses |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_hi | output | 1 | Group 2 interrupt |
| irq_lo | output | 1 | Group 1 interrupt |
| err_pin | output | 1 | Error output level, low = error |
| err_pin_oe | output | 1 | Error output driver enable |

## Verification
Two operations can land in the same cycle, and the bench drives each such pair together.

The first pair is a key release and a new group 3 event. The key write to address 10 and the event pulse are driven from the same falling edge. The result is judged by reading `err_pin` after the next rising edge: it must still be low, and a later key write alone must release it.

The second pair is a high-priority offset read and a fresh event on the channel that read reports. The read must return that channel plus one. A status read afterwards must show the group 2 flag still set.

// File: rtl/esa_pkg.sv
package esa_pkg;

   // Word addresses of the register bus
   typedef enum logic [3:0] {
      A_G1L   = 4'd0,
      A_G1H   = 4'd1,
      A_G2    = 4'd2,
      A_G3    = 4'd3,
      A_SHD   = 4'd4,
      A_PIN   = 4'd5,
      A_IEL   = 4'd6,
      A_IEH   = 4'd7,
      A_PEL   = 4'd8,
      A_PEH   = 4'd9,
      A_KEY   = 4'd10,
      A_OFFHI = 4'd11,
      A_OFFLO = 4'd12,
      A_FORCE = 4'd13
   } esa_addr_e;

endpackage

// File: rtl/esa_flag_bank.sv
module esa_flag_bank #(
   parameter int unsigned W          = 32,
   parameter bit          WARM_CLEAR = 1'b0
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         warm_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] flags_o
);

   logic [W-1:0] flags_q;
   logic [W-1:0] flags_d;

   // a set in the same cycle as a clear keeps the flag
   assign flags_d = (flags_q & ~clr_i) | set_i;

   generate
      if (WARM_CLEAR) begin : g_warm_domain
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)       flags_q <= '0;
            else if (!warm_n) flags_q <= '0;
            else              flags_q <= flags_d;
         end
         AST_WARM_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
            !warm_n |=> (flags_q == '0)); // R8
      end else begin : g_por_domain
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) flags_q <= '0;
            else        flags_q <= flags_d;
         end
      end
   endgenerate

   assign flags_o = flags_q;

   AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!por_n)
      ((|set_i) && (warm_n || !WARM_CLEAR)) |=> (($past(set_i) & ~flags_q) == '0)); // R1

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      (warm_n || !WARM_CLEAR) |=> ((($past(flags_q) & ~$past(clr_i)) & ~flags_q) == '0)); // R1

   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
      (|(clr_i & ~set_i)) |=> (($past(clr_i & ~set_i) & flags_q) == '0)); // R2

endmodule

// File: rtl/esa_lowest_enc.sv
module esa_lowest_enc #(
   parameter int unsigned W  = 32,
   parameter int unsigned CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] code_o
);

   initial begin
      if (CW < $clog2(W + 1)) $error("esa_lowest_enc: code width too small");
   end

   always_comb begin
      code_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i]) code_o = CW'(i + 1);
      end
   end

   always_comb begin
      if (vec_i == '0) AST_ENC_EMPTY: assert (code_o == '0); // R10
      if (vec_i[0])    AST_ENC_FIRST: assert (code_o == CW'(1)); // R11
   end

endmodule

// File: rtl/esa_pin_latch.sv
module esa_pin_latch (
   input  logic clk,
   input  logic por_n,
   input  logic trig_i,
   input  logic rel_i,
   output logic latched_o
);

   logic latched_q;

   // not in the warm reset domain: the level survives warm reset
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) latched_q <= 1'b0;
      else        latched_q <= trig_i | (latched_q & ~rel_i);
   end

   assign latched_o = latched_q;

   AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
      (latched_q && !rel_i) |=> latched_q); // R5

   AST_PIN_RELEASES: assert property (@(posedge clk) disable iff (!por_n)
      (rel_i && !trig_i) |=> !latched_q); // R5

   AST_PIN_TRIPS: assert property (@(posedge clk) disable iff (!por_n)
      trig_i |=> latched_q); // R4

endmodule

// File: rtl/esa_top.sv
module esa_top
   import esa_pkg::*;
#(
   parameter int unsigned DW      = 32,
   parameter int unsigned G1_W    = 64,
   parameter int unsigned G2_W    = 32,
   parameter int unsigned G3_W    = 32,
   parameter int unsigned KEY_W   = 4,
   parameter logic [3:0]  KEY_REL = 4'h5
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            warm_n,
   input  logic [G1_W-1:0] evt_g1,
   input  logic [G2_W-1:0] evt_g2,
   input  logic [G3_W-1:0] evt_g3,
   input  logic            bus_sel,
   input  logic            bus_wr,
   input  logic [3:0]      bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   output logic            irq_hi,
   output logic            irq_lo,
   output logic            err_pin,
   output logic            err_pin_oe
);

   localparam int unsigned G1C_W = $clog2(G1_W + 1);
   localparam int unsigned G2C_W = $clog2(G2_W + 1);

   generate
      if (G1_W != 2 * DW) begin : g_bad_g1
         $error("esa_top: group 1 must span exactly two bus words");
      end
      if (G2_W > DW || G3_W > DW) begin : g_bad_g23
         $error("esa_top: group 2 and group 3 must fit one bus word");
      end
      if (KEY_W > DW || KEY_W > 4 || KEY_W == 0) begin : g_bad_key
         $error("esa_top: key width out of range");
      end
   endgenerate

   // Bus decode
   logic wr_en, rd_en, rd_hi, rel_key, force_err;
   assign wr_en     = bus_sel & bus_wr & warm_n;
   assign rd_en     = bus_sel & ~bus_wr & warm_n;
   assign rd_hi     = rd_en & (bus_addr == A_OFFHI);
   assign rel_key   = wr_en & (bus_addr == A_KEY) & (bus_wdata[KEY_W-1:0] == KEY_REL[KEY_W-1:0]);
   assign force_err = wr_en & (bus_addr == A_FORCE) & bus_wdata[0];

   // Configuration registers (warm reset domain)
   logic [G1_W-1:0]  ien_q, pen_q;
   logic [KEY_W-1:0] key_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ien_q <= '0;
         pen_q <= '0;
         key_q <= '0;
      end else if (!warm_n) begin
         ien_q <= '0;
         pen_q <= '0;
         key_q <= '0;
      end else if (wr_en) begin
         case (bus_addr)
            A_IEL:   ien_q[DW-1:0]    <= bus_wdata;
            A_IEH:   ien_q[G1_W-1:DW] <= bus_wdata;
            A_PEL:   pen_q[DW-1:0]    <= bus_wdata;
            A_PEH:   pen_q[G1_W-1:DW] <= bus_wdata;
            A_KEY:   key_q            <= bus_wdata[KEY_W-1:0];
            default: ;
         endcase
      end
   end

   // Flag banks
   logic [G1_W-1:0] g1_q, clr_g1;
   logic [G2_W-1:0] g2_q, shd_q, clr_g2;
   logic [G3_W-1:0] g3_q;
   logic [G1C_W-1:0] lo_code;
   logic [G2C_W-1:0] hi_code;

   assign clr_g1[DW-1:0]    = (wr_en && bus_addr == A_G1L) ? bus_wdata : '0;
   assign clr_g1[G1_W-1:DW] = (wr_en && bus_addr == A_G1H) ? bus_wdata : '0;

   generate
      for (genvar i = 0; i < G2_W; i++) begin : g_hi_clr
         assign clr_g2[i] = rd_hi & (hi_code == G2C_W'(i + 1));
      end
   endgenerate

   esa_flag_bank #(.W(G1_W), .WARM_CLEAR(1'b0)) u_g1 (
      .clk(clk), .por_n(por_n), .warm_n(warm_n),
      .set_i(evt_g1), .clr_i(clr_g1), .flags_o(g1_q));

   esa_flag_bank #(.W(G2_W), .WARM_CLEAR(1'b1)) u_g2 (
      .clk(clk), .por_n(por_n), .warm_n(warm_n),
      .set_i(evt_g2), .clr_i(clr_g2), .flags_o(g2_q));

   esa_flag_bank #(.W(G2_W), .WARM_CLEAR(1'b0)) u_shadow (
      .clk(clk), .por_n(por_n), .warm_n(warm_n),
      .set_i(evt_g2), .clr_i({G2_W{1'b0}}), .flags_o(shd_q));

   esa_flag_bank #(.W(G3_W), .WARM_CLEAR(1'b0)) u_g3 (
      .clk(clk), .por_n(por_n), .warm_n(warm_n),
      .set_i(evt_g3), .clr_i({G3_W{1'b0}}), .flags_o(g3_q));

   // Offset encoders
   esa_lowest_enc #(.W(G2_W), .CW(G2C_W)) u_enc_hi (.vec_i(g2_q), .code_o(hi_code));
   esa_lowest_enc #(.W(G1_W), .CW(G1C_W)) u_enc_lo (.vec_i(g1_q), .code_o(lo_code));

   // Error output
   logic pin_trip, pin_low;
   assign pin_trip = (|(evt_g1 & pen_q)) | (|evt_g2) | (|evt_g3) | force_err;

   esa_pin_latch u_pin (
      .clk(clk), .por_n(por_n), .trig_i(pin_trip), .rel_i(rel_key), .latched_o(pin_low));

   assign err_pin    = ~pin_low;
   assign err_pin_oe = por_n;

   // Interrupts
   assign irq_lo = |(g1_q & ien_q);
   assign irq_hi = |g2_q;

   // Read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (bus_addr)
            A_G1L:   bus_rdata = g1_q[DW-1:0];
            A_G1H:   bus_rdata = g1_q[G1_W-1:DW];
            A_G2:    bus_rdata = DW'(g2_q);
            A_G3:    bus_rdata = DW'(g3_q);
            A_SHD:   bus_rdata = DW'(shd_q);
            A_PIN:   bus_rdata = DW'(err_pin);
            A_IEL:   bus_rdata = ien_q[DW-1:0];
            A_IEH:   bus_rdata = ien_q[G1_W-1:DW];
            A_PEL:   bus_rdata = pen_q[DW-1:0];
            A_PEH:   bus_rdata = pen_q[G1_W-1:DW];
            A_KEY:   bus_rdata = DW'(key_q);
            A_OFFHI: bus_rdata = DW'(hi_code);
            A_OFFLO: bus_rdata = DW'(lo_code);
            default: bus_rdata = '0;
         endcase
      end
   end

   AST_SHADOW_COVERS: assert property (@(posedge clk) disable iff (!por_n)
      ((g2_q & ~shd_q) == '0)); // R6

   AST_SHADOW_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
      1'b1 |=> (($past(shd_q) & ~shd_q) == '0)); // R6

   AST_G1_WARM_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
      (!warm_n && evt_g1 == '0) |=> (g1_q == $past(g1_q))); // R8

   AST_PIN_WARM_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
      (!warm_n && !pin_trip) |=> (err_pin == $past(err_pin))); // R8

endmodule

// File: tb/tb_esa_top.sv
module tb_esa_top;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        warm_n = 1'b1;
   logic [63:0] evt_g1 = '0;
   logic [31:0] evt_g2 = '0;
   logic [31:0] evt_g3 = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_hi, irq_lo, err_pin, err_pin_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   esa_top dut (
      .clk(clk), .por_n(por_n), .warm_n(warm_n),
      .evt_g1(evt_g1), .evt_g2(evt_g2), .evt_g3(evt_g3),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_hi(irq_hi), .irq_lo(irq_lo), .err_pin(err_pin), .err_pin_oe(err_pin_oe));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
      logic [31:0] d;
      rd_reg(a, d);
      chk(req, d, exp);
   endtask

   task automatic pulse(input int grp, input int ch);
      @(negedge clk);
      if (grp == 1) evt_g1[ch] = 1'b1;
      else if (grp == 2) evt_g2[ch] = 1'b1;
      else evt_g3[ch] = 1'b1;
      @(negedge clk);
      evt_g1 = '0; evt_g2 = '0; evt_g3 = '0;
   endtask

   task automatic t_por();
      #5 chk("R7 oe during por", 32'(err_pin_oe), 32'd0);
      @(negedge clk); @(negedge clk);
      por_n = 1'b1;
      chk("R7 oe after por", 32'(err_pin_oe), 32'd1);
      chk("R7 pin after por", 32'(err_pin), 32'd1);
      chk("R7 irq after por", {30'd0, irq_hi, irq_lo}, 32'd0);
      for (int a = 0; a < 5; a++) rd_chk(4'(a), 32'd0, "R7 status clear");
      rd_chk(4'd11, 32'd0, "R7 hi offset empty");
      rd_chk(4'd12, 32'd0, "R7 lo offset empty");
   endtask

   task automatic t_g1_w1c();
      pulse(1, 3);
      pulse(1, 40);
      rd_chk(4'd0, 32'h8, "R1 g1 low word");
      rd_chk(4'd1, 32'h100, "R1 g1 high word");
      chk("R4 g1 without pin enable", 32'(err_pin), 32'd1);
      wr_reg(4'd0, 32'h0);
      rd_chk(4'd0, 32'h8, "R2 zero write keeps");
      wr_reg(4'd0, 32'h8);
      wr_reg(4'd1, 32'h100);
      rd_chk(4'd0, 32'h0, "R2 w1c low");
      rd_chk(4'd1, 32'h0, "R2 w1c high");
   endtask

   task automatic t_irq();
      wr_reg(4'd6, 32'h20);
      pulse(1, 4);
      chk("R3 irq_lo masked", 32'(irq_lo), 32'd0);
      pulse(1, 5);
      chk("R3 irq_lo enabled", 32'(irq_lo), 32'd1);
      chk("R3 irq_hi idle", 32'(irq_hi), 32'd0);
      wr_reg(4'd0, 32'h10);
      pulse(2, 2);
      chk("R3 irq_hi", 32'(irq_hi), 32'd1);
      chk("R4 g2 drives pin", 32'(err_pin), 32'd0);
      rd_chk(4'd5, 32'd0, "R4 pin status low");
      rd_chk(4'd2, 32'h4, "R1 g2 word");
   endtask

   task automatic t_key();
      wr_reg(4'd10, 32'h3);
      chk("R5 wrong key", 32'(err_pin), 32'd0);
      wr_reg(4'd10, 32'hA);
      chk("R5 wrong key 2", 32'(err_pin), 32'd0);
      wr_reg(4'd10, 32'h5);
      chk("R5 key release", 32'(err_pin), 32'd1);
      rd_chk(4'd5, 32'd1, "R4 pin status high");
   endtask

   task automatic t_pin_en();
      wr_reg(4'd8, 32'h80);
      pulse(1, 7);
      chk("R4 g1 pin enabled", 32'(err_pin), 32'd0);
      wr_reg(4'd10, 32'h5);
      chk("R5 release g1", 32'(err_pin), 32'd1);
      pulse(3, 0);
      chk("R4 g3 drives pin", 32'(err_pin), 32'd0);
      rd_chk(4'd3, 32'h1, "R1 g3 word");
      wr_reg(4'd10, 32'h5);
      chk("R5 release g3", 32'(err_pin), 32'd1);
   endtask

   task automatic t_offsets();
      pulse(2, 9);
      pulse(2, 4);
      rd_chk(4'd11, 32'd3, "R10 hi offset ch2");
      rd_chk(4'd11, 32'd5, "R10 hi offset ch4");
      rd_chk(4'd2, 32'h200, "R10 one flag cleared");
      rd_chk(4'd11, 32'd10, "R10 hi offset ch9");
      rd_chk(4'd11, 32'd0, "R10 hi offset empty");
      chk("R3 irq_hi drained", 32'(irq_hi), 32'd0);
      rd_chk(4'd4, 32'h214, "R6 shadow after offset reads");
      rd_chk(4'd0, 32'hA0, "R10 g1 untouched");
      rd_chk(4'd12, 32'd6, "R11 lo offset");
      rd_chk(4'd12, 32'd6, "R11 lo offset no clear");
      rd_chk(4'd0, 32'hA0, "R11 g1 kept");
      wr_reg(4'd10, 32'h5);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      pulse(3, 0);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd10; bus_wdata = 32'h5;
      evt_g3[1] = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; evt_g3 = '0;
      chk("R5 event beats release", 32'(err_pin), 32'd0);
      wr_reg(4'd10, 32'h5);
      chk("R5 release after collision", 32'(err_pin), 32'd1);
      pulse(2, 0);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd11;
      evt_g2[0] = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0; evt_g2 = '0;
      chk("R10 hi offset during event", d, 32'd1);
      rd_chk(4'd2, 32'h1, "R10 event beats read clear");
      wr_reg(4'd10, 32'h5);
   endtask

   task automatic t_force();
      chk("R12 pin before force", 32'(err_pin), 32'd1);
      wr_reg(4'd13, 32'h0);
      chk("R12 force bit clear", 32'(err_pin), 32'd1);
      wr_reg(4'd13, 32'h1);
      chk("R12 forced low", 32'(err_pin), 32'd0);
      rd_chk(4'd5, 32'd0, "R12 pin status forced");
   endtask

   task automatic t_warm();
      @(negedge clk);
      warm_n = 1'b0;
      @(negedge clk);
      chk("R8 oe during warm", 32'(err_pin_oe), 32'd1);
      @(negedge clk);
      warm_n = 1'b1;
      chk("R8 pin kept", 32'(err_pin), 32'd0);
      chk("R8 irq_lo off", 32'(irq_lo), 32'd0);
      rd_chk(4'd2, 32'h0, "R8 g2 cleared");
      rd_chk(4'd0, 32'hA0, "R8 g1 kept");
      rd_chk(4'd3, 32'h3, "R8 g3 kept");
      rd_chk(4'd4, 32'h215, "R6 shadow kept by warm");
      rd_chk(4'd6, 32'h0, "R8 enables cleared");
      wr_reg(4'd6, 32'h20);
      chk("R9 irq after re-enable", 32'(irq_lo), 32'd1);
   endtask

   task automatic t_por_again();
      @(negedge clk);
      por_n = 1'b0;
      #1 chk("R7 oe off in por", 32'(err_pin_oe), 32'd0);
      @(negedge clk);
      por_n = 1'b1;
      rd_chk(4'd4, 32'h0, "R6 shadow cleared by por");
      rd_chk(4'd0, 32'h0, "R7 g1 cleared");
      rd_chk(4'd3, 32'h0, "R7 g3 cleared");
      chk("R7 pin released by por", 32'(err_pin), 32'd1);
   endtask

   initial begin
      t_por();
      t_g1_w1c();
      t_irq();
      t_key();
      t_pin_en();
      t_offsets();
      t_collide();
      t_force();
      t_warm();
      t_por_again();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule